// File: doc/BRIEF.md
# RTC Register and Interrupt Unit

This block is the register front end of a real-time clock. It holds a 32-bit seconds counter that software can load, and a sub-second count of fractional ticks. A programmable alarm value is compared against the seconds counter. Two events are recorded in a status register. The seconds event occurs on every seconds tick. The alarm event occurs when a tick makes the counter equal to the alarm value. Each event drives its own interrupt line, gated by a mask bit.

Software reaches the block over a simple 32-bit register bus with a write strobe and a read strobe. Read data is registered and appears on the cycle after the read strobe. A prescaler outside the block supplies one-cycle pulses on `sec_tick` and `frac_tick`. The block hands the stored calibration word and the oscillator enable bit back to that prescaler.

Register offsets (byte addresses):

| Offset | Access | Content |
|--------|--------|---------|
| 0x00 | write | time load |
| 0x04 | read | last value written to the time load |
| 0x08 | write | calibration word, 21 bits |
| 0x0C | read | calibration word |
| 0x10 | read | current seconds |
| 0x14 | read | current sub-second tick count |
| 0x18 | read/write | alarm value |
| 0x20 | read / write-one-to-clear | interrupt status |
| 0x24 | read | interrupt mask |
| 0x28 | write | set mask bits |
| 0x2C | write | clear mask bits |
| 0x40 | read/write | control, bit 24 is the oscillator enable |

Top module: `rtc_regblk`

## Requirements
- R1: After reset, the seconds counter, the tick count, the status register, the mask register, the alarm value, the calibration word, the control bit and `rdata` are all 0. Both interrupt outputs are low.
- R2: A write to 0x00 loads the seconds counter on that clock edge and clears the tick count at 0x14. A read of 0x04 returns the last value written to 0x00.
- R3: Each `sec_tick` pulse increments the seconds counter at 0x10, and the counter wraps from 0xFFFFFFFF to 0. A load at 0x00 in the same cycle as a tick takes precedence over the tick.
- R4: Each `frac_tick` pulse increments the tick count at 0x14. A `sec_tick` pulse clears the count, and the clear takes precedence over a `frac_tick` in the same cycle.
- R5: Status bit 0 (the seconds event) is set on every `sec_tick` pulse, whether or not its mask bit is set.
- R6: Status bit 1 (the alarm event) is set on the tick that makes the seconds counter equal to the alarm value at 0x18. A tick that leaves the counter at any other value does not set it.
- R7: Writing 0x20 clears each status bit whose write-data bit is 1 and leaves bits written with 0 unchanged. An event that sets a bit wins over a clear of that bit in the same cycle.
- R8: Writing a 1 to bit n of 0x28 sets mask bit n. Writing a 1 to bit n of 0x2C clears mask bit n. Bits written with 0 are unchanged. The mask is read at 0x24.
- R9: `irq_sec` is high exactly when status bit 0 and mask bit 0 are both set. `irq_alarm` is high exactly when status bit 1 and mask bit 1 are both set. Each line stays high until its status bit is cleared or its mask bit is cleared.
- R10: A write to 0x08 stores the low 21 bits of the write data. That value is read at 0x0C and driven on `calib_word`. A write to 0x40 stores bit 24, which is read back at bit 24 of 0x40 and drives `osc_en`. All other bits of 0x40 read 0.
- R11: Reads of the write-only offsets 0x00, 0x08, 0x28 and 0x2C, and of any unmapped offset, return 0. `rdata` updates only on the cycle after `rd_en` and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data, valid on the cycle after `rd_en` |
| sec_tick | input | 1 | One-cycle pulse that marks a second |
| frac_tick | input | 1 | One-cycle pulse that marks a sub-second tick |
| calib_word | output | 21 | Stored calibration word for the prescaler |
| osc_en | output | 1 | Oscillator enable |
| irq_alarm | output | 1 | Alarm interrupt line |
| irq_sec | output | 1 | Seconds interrupt line |

## Verification
The hardest cases to reach from the ports are collisions inside a single cycle. These are a status clear landing in the same cycle as a seconds event, and a time load landing in the same cycle as a tick. The bench reaches them with a combined task that raises `sec_tick` and the write strobe on the same falling edge, then reads the status and the counter back. The alarm is approached by loading the counter to two below the alarm value and ticking twice. The status is checked after each tick, so the bench confirms that the bit appears only on the tick that lands on the alarm value. The wrap is reached directly, by loading 0xFFFFFFFF and ticking once.

// File: rtl/rtc_regblk_pkg.sv
package rtc_regblk_pkg;
  localparam logic [7:0] OFS_TLOAD_WR = 8'h00;
  localparam logic [7:0] OFS_TLOAD_RD = 8'h04;
  localparam logic [7:0] OFS_CAL_WR   = 8'h08;
  localparam logic [7:0] OFS_CAL_RD   = 8'h0C;
  localparam logic [7:0] OFS_SECS     = 8'h10;
  localparam logic [7:0] OFS_FRAC     = 8'h14;
  localparam logic [7:0] OFS_ALARM    = 8'h18;
  localparam logic [7:0] OFS_STS      = 8'h20;
  localparam logic [7:0] OFS_MASK     = 8'h24;
  localparam logic [7:0] OFS_MSET     = 8'h28;
  localparam logic [7:0] OFS_MCLR     = 8'h2C;
  localparam logic [7:0] OFS_CTRL     = 8'h40;

  localparam int IRQ_N       = 2;
  localparam int IRQ_SEC_BIT = 0;
  localparam int IRQ_ALM_BIT = 1;
  localparam int OSC_BIT     = 24;
endpackage

// File: rtl/rtc_sec_counter.sv
module rtc_sec_counter #(
  parameter int CNT_W  = 32,
  parameter int TICK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              sec_tick,
  input  logic              frac_tick,
  input  logic [CNT_W-1:0]  alarm_val,
  output logic [CNT_W-1:0]  sec_cnt,
  output logic [TICK_W-1:0] frac_cnt,
  output logic              alarm_hit
);
  logic [CNT_W-1:0]  cnt_inc;
  logic [CNT_W-1:0]  cnt_nxt;
  logic              cnt_ce;
  logic [TICK_W-1:0] frac_nxt;
  logic              frac_ce;

  always_comb begin
    cnt_inc   = sec_cnt + CNT_W'(1);
    cnt_ce    = load_en | sec_tick;
    cnt_nxt   = load_en ? load_val : cnt_inc;
    frac_ce   = load_en | sec_tick | frac_tick;
    frac_nxt  = (load_en | sec_tick) ? '0 : frac_cnt + TICK_W'(1);
    alarm_hit = sec_tick & ~load_en & (cnt_inc == alarm_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sec_cnt <= '0;
    end else if (cnt_ce) begin
      sec_cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frac_cnt <= '0;
    end else if (frac_ce) begin
      frac_cnt <= frac_nxt;
    end
  end
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt_set,
  input  logic [N-1:0] sts_clr,
  input  logic [N-1:0] msk_set,
  input  logic [N-1:0] msk_clr,
  output logic [N-1:0] sts,
  output logic [N-1:0] msk,
  output logic [N-1:0] irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic sts_nxt;
    logic msk_nxt;
    logic sts_ce;
    logic msk_ce;

    always_comb begin
      sts_ce  = evt_set[i] | sts_clr[i];
      sts_nxt = evt_set[i];
      msk_ce  = msk_set[i] | msk_clr[i];
      msk_nxt = ~msk_clr[i];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sts[i] <= 1'b0;
      end else if (sts_ce) begin
        sts[i] <= sts_nxt;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        msk[i] <= 1'b0;
      end else if (msk_ce) begin
        msk[i] <= msk_nxt;
      end
    end

    assign irq[i] = sts[i] & msk[i];
  end
endmodule

// File: rtl/rtc_regfile.sv
module rtc_regfile
  import rtc_regblk_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int TICK_W = 16,
  parameter int CAL_W  = 21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [AW-1:0]     addr,
  input  logic [DW-1:0]     wdata,
  input  logic [DW-1:0]     sec_cnt,
  input  logic [TICK_W-1:0] frac_cnt,
  input  logic [IRQ_N-1:0]  sts,
  input  logic [IRQ_N-1:0]  msk,
  output logic              load_en,
  output logic [DW-1:0]     alarm_val,
  output logic [IRQ_N-1:0]  sts_clr,
  output logic [IRQ_N-1:0]  msk_set,
  output logic [IRQ_N-1:0]  msk_clr,
  output logic [CAL_W-1:0]  calib_word,
  output logic              osc_en,
  output logic [DW-1:0]     rdata
);
  logic [DW-1:0] tload_shadow;
  logic          wr_tload, wr_cal, wr_alarm, wr_sts, wr_mset, wr_mclr, wr_ctrl;
  logic [DW-1:0] rd_mux;

  function automatic logic hit(input logic [AW-1:0] a, input logic [7:0] ofs);
    return a == AW'(ofs);
  endfunction

  always_comb begin
    wr_tload = wr_en & hit(addr, OFS_TLOAD_WR);
    wr_cal   = wr_en & hit(addr, OFS_CAL_WR);
    wr_alarm = wr_en & hit(addr, OFS_ALARM);
    wr_sts   = wr_en & hit(addr, OFS_STS);
    wr_mset  = wr_en & hit(addr, OFS_MSET);
    wr_mclr  = wr_en & hit(addr, OFS_MCLR);
    wr_ctrl  = wr_en & hit(addr, OFS_CTRL);
    load_en  = wr_tload;
    sts_clr  = wr_sts  ? wdata[IRQ_N-1:0] : '0;
    msk_set  = wr_mset ? wdata[IRQ_N-1:0] : '0;
    msk_clr  = wr_mclr ? wdata[IRQ_N-1:0] : '0;
  end

  always_comb begin
    rd_mux = '0;
    if (hit(addr, OFS_TLOAD_RD)) rd_mux = tload_shadow;
    if (hit(addr, OFS_CAL_RD))   rd_mux = DW'(calib_word);
    if (hit(addr, OFS_SECS))     rd_mux = sec_cnt;
    if (hit(addr, OFS_FRAC))     rd_mux = DW'(frac_cnt);
    if (hit(addr, OFS_ALARM))    rd_mux = alarm_val;
    if (hit(addr, OFS_STS))      rd_mux = DW'(sts);
    if (hit(addr, OFS_MASK))     rd_mux = DW'(msk);
    if (hit(addr, OFS_CTRL))     rd_mux[OSC_BIT] = osc_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tload_shadow <= '0;
    end else if (wr_tload) begin
      tload_shadow <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      calib_word <= '0;
    end else if (wr_cal) begin
      calib_word <= wdata[CAL_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alarm_val <= '0;
    end else if (wr_alarm) begin
      alarm_val <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_en <= 1'b0;
    end else if (wr_ctrl) begin
      osc_en <= wdata[OSC_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata <= '0;
    end else if (rd_en) begin
      rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/rtc_regblk.sv
module rtc_regblk
  import rtc_regblk_pkg::*;
#(
  parameter int AW     = 8,
  parameter int DW     = 32,
  parameter int TICK_W = 16,
  parameter int CAL_W  = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic             sec_tick,
  input  logic             frac_tick,
  output logic [CAL_W-1:0] calib_word,
  output logic             osc_en,
  output logic             irq_alarm,
  output logic             irq_sec
);
  logic [DW-1:0]     sec_cnt;
  logic [TICK_W-1:0] frac_cnt;
  logic [DW-1:0]     alarm_val;
  logic              load_en;
  logic              alarm_hit;
  logic [IRQ_N-1:0]  evt_set, sts_clr, msk_set, msk_clr, sts, msk, irq;

  rtc_sec_counter #(.CNT_W(DW), .TICK_W(TICK_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(wdata),
    .sec_tick(sec_tick), .frac_tick(frac_tick), .alarm_val(alarm_val),
    .sec_cnt(sec_cnt), .frac_cnt(frac_cnt), .alarm_hit(alarm_hit)
  );

  always_comb begin
    evt_set              = '0;
    evt_set[IRQ_SEC_BIT] = sec_tick;
    evt_set[IRQ_ALM_BIT] = alarm_hit;
  end

  rtc_irq_ctrl #(.N(IRQ_N)) u_irq (
    .clk(clk), .rst_n(rst_n), .evt_set(evt_set), .sts_clr(sts_clr),
    .msk_set(msk_set), .msk_clr(msk_clr), .sts(sts), .msk(msk), .irq(irq)
  );

  rtc_regfile #(.AW(AW), .DW(DW), .TICK_W(TICK_W), .CAL_W(CAL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .sec_cnt(sec_cnt), .frac_cnt(frac_cnt), .sts(sts),
    .msk(msk), .load_en(load_en), .alarm_val(alarm_val), .sts_clr(sts_clr),
    .msk_set(msk_set), .msk_clr(msk_clr), .calib_word(calib_word),
    .osc_en(osc_en), .rdata(rdata)
  );

  assign irq_sec   = irq[IRQ_SEC_BIT];
  assign irq_alarm = irq[IRQ_ALM_BIT];
endmodule

// File: rtl/rtc_regblk_chk.sv
module rtc_regblk_chk
  import rtc_regblk_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_en,
  input logic          rd_en,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] rdata,
  input logic          sec_tick,
  input logic          irq_sec,
  input logic          irq_alarm,
  input logic [DW-1:0] sec_cnt,
  input logic [1:0]    sts,
  input logic [1:0]    msk,
  input logic          alarm_hit
);
  logic is_load, is_sts, is_mset, is_mclr;
  assign is_load = wr_en && addr == AW'(OFS_TLOAD_WR);
  assign is_sts  = wr_en && addr == AW'(OFS_STS);
  assign is_mset = wr_en && addr == AW'(OFS_MSET);
  assign is_mclr = wr_en && addr == AW'(OFS_MCLR);

  p_load_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    is_load |=> sec_cnt == $past(wdata));

  p_tick_incr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !is_load) |=> sec_cnt == DW'($past(sec_cnt) + DW'(1)));

  p_sec_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sec_tick |=> sts[0]);

  p_alarm_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_sts && wdata[1] && !alarm_hit) |=> !sts[1]);

  p_mask_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (is_mset && wdata[1]) |=> msk[1]);

  p_irq_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_sec && !(is_sts && wdata[0]) && !(is_mclr && wdata[0])) |=> irq_sec);

  p_alarm_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_alarm && !(is_sts && wdata[1]) && !(is_mclr && wdata[1])) |=> irq_alarm);

  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

bind rtc_regblk rtc_regblk_chk #(.AW(AW), .DW(DW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick), .irq_sec(irq_sec),
  .irq_alarm(irq_alarm), .sec_cnt(sec_cnt), .sts(sts), .msk(msk),
  .alarm_hit(alarm_hit)
);

// File: tb/rtc_regblk_tb_top.sv
module rtc_regblk_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sec_tick = 1'b0, frac_tick = 1'b0;
  logic [20:0] calib_word;
  logic        osc_en, irq_alarm, irq_sec;

  int n_cmp = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  rtc_regblk dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .sec_tick(sec_tick), .frac_tick(frac_tick),
    .calib_word(calib_word), .osc_en(osc_en), .irq_alarm(irq_alarm),
    .irq_sec(irq_sec)
  );

  // vector: {is_read, req, addr, data/expected}
  localparam int NV = 16;
  localparam logic [44:0] VEC [NV] = '{
    {1'b0, 4'd6,  8'h18, 32'h0000_1234},  // R6 alarm write
    {1'b1, 4'd6,  8'h18, 32'h0000_1234},  // R6 alarm readback
    {1'b0, 4'd10, 8'h08, 32'hFFFF_FFFF},  // R10
    {1'b1, 4'd10, 8'h0C, 32'h001F_FFFF},  // R10 masked to 21 bits
    {1'b0, 4'd10, 8'h40, 32'hFFFF_FFFF},  // R10
    {1'b1, 4'd10, 8'h40, 32'h0100_0000},  // R10 only bit 24
    {1'b0, 4'd2,  8'h00, 32'hDEAD_BEEF},  // R2 load
    {1'b1, 4'd2,  8'h04, 32'hDEAD_BEEF},  // R2 shadow
    {1'b1, 4'd2,  8'h10, 32'hDEAD_BEEF},  // R2 counter loaded
    {1'b1, 4'd11, 8'h00, 32'h0000_0000},  // R11 write-only
    {1'b1, 4'd11, 8'h08, 32'h0000_0000},  // R11 write-only
    {1'b0, 4'd8,  8'h28, 32'h0000_0003},  // R8 set both
    {1'b1, 4'd8,  8'h24, 32'h0000_0003},  // R8
    {1'b0, 4'd8,  8'h2C, 32'h0000_0001},  // R8 clear bit 0
    {1'b1, 4'd8,  8'h24, 32'h0000_0002},  // R8
    {1'b1, 4'd11, 8'h7C, 32'h0000_0000}   // R11 unmapped
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(posedge clk);
    @(negedge clk); rd_en = 1'b0; d = rdata;
  endtask

  task automatic rdchk(input int req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] d;
    rd(a, d);
    check(req, d, exp);
  endtask

  task automatic pulse(input bit s, input bit f);
    @(negedge clk); sec_tick = s; frac_tick = f;
    @(posedge clk);
    @(negedge clk); sec_tick = 1'b0; frac_tick = 1'b0;
  endtask

  task automatic wr_tick(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d; sec_tick = 1'b1;
    @(posedge clk);
    @(negedge clk); wr_en = 1'b0; sec_tick = 1'b0;
  endtask

  initial begin
    #1_000_000;
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check(1, {30'd0, irq_alarm, irq_sec}, 32'd0);
    check(1, {31'd0, osc_en}, 32'd0);
    check(1, rdata, 32'd0);
    rdchk(1, 8'h10, 32'd0);
    rdchk(1, 8'h20, 32'd0);
    rdchk(1, 8'h24, 32'd0);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][44]) rdchk(int'(VEC[i][43:40]), VEC[i][39:32], VEC[i][31:0]);
      else            wr(VEC[i][39:32], VEC[i][31:0]);
    end
    check(10, {10'd0, calib_word, osc_en}, {10'd0, 21'h1F_FFFF, 1'b1});

    // R11 rdata holds without rd_en
    @(negedge clk); addr = 8'h18;
    repeat (2) @(negedge clk);
    check(11, rdata, 32'd0);

    // R4 fractional count, R2 load clears it
    wr(8'h00, 32'h100);
    repeat (3) pulse(1'b0, 1'b1);
    rdchk(4, 8'h14, 32'd3);
    wr(8'h00, 32'h100);
    rdchk(2, 8'h14, 32'd0);
    pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b1);                 // R4 clear wins over frac
    rdchk(4, 8'h14, 32'd0);
    rdchk(3, 8'h10, 32'h101);
    // R5 seconds event though mask bit 0 is clear
    rdchk(5, 8'h20, 32'd1);
    check(5, {31'd0, irq_sec}, 32'd0);

    // R6 alarm
    wr(8'h20, 32'h3);
    wr(8'h18, 32'h105);
    wr(8'h00, 32'h103);
    pulse(1'b1, 1'b0);
    rdchk(6, 8'h20, 32'd1);
    check(9, {31'd0, irq_alarm}, 32'd0);
    pulse(1'b1, 1'b0);
    rdchk(6, 8'h20, 32'd3);
    check(9, {30'd0, irq_alarm, irq_sec}, 32'd2);

    // R7 write zero ignored, write one clears
    wr(8'h20, 32'h0);
    rdchk(7, 8'h20, 32'd3);
    wr(8'h20, 32'h2);
    rdchk(7, 8'h20, 32'd1);
    check(9, {31'd0, irq_alarm}, 32'd0);
    // R7 set wins over clear
    wr_tick(8'h20, 32'h1);
    rdchk(7, 8'h20, 32'd1);

    // R3 load beats tick; wrap
    wr_tick(8'h00, 32'h55);
    rdchk(3, 8'h10, 32'h55);
    wr(8'h00, 32'hFFFF_FFFF);
    pulse(1'b1, 1'b0);
    rdchk(3, 8'h10, 32'd0);

    // R9 seconds line with mask
    wr(8'h28, 32'h1);
    check(9, {31'd0, irq_sec}, 32'd1);
    wr(8'h20, 32'h1);
    check(9, {31'd0, irq_sec}, 32'd0);
    pulse(1'b1, 1'b0);
    check(9, {31'd0, irq_sec}, 32'd1);
    wr(8'h2C, 32'h1);
    check(9, {31'd0, irq_sec}, 32'd0);
    rdchk(8, 8'h24, 32'd2);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule